// File: doc/BRIEF.md
# Hold-to-Toggle Latch with Shut-off and Release Delays

This block keeps one bit of state and flips it when a pair of inputs that should always disagree instead agree for long enough. The two inputs, `pair_a` and `pair_b`, normally form a complementary pair. Each one first passes through its own two-stage synchronizer. When the synchronized pair shows the same level for `HOLD_CYCLES` consecutive clock cycles, the stored bit inverts exactly once. Both-high and both-low holds have the same effect. The bit comes out in true form on `state_q` and inverted form on `state_qn`.

A flag output reports the abnormal pair condition. It is a tri-state pin modelled as a data bit, `flag_o`, plus an enable, `flag_oe`. When the flag is driven, it is driven low. It goes to high impedance as soon as the synchronized pair agrees. Once the pair becomes complementary again, the flag is driven low only after `RELEASE_CYCLES` further cycles of complementary input.

An active-high reset, `rst`, asserts asynchronously. It clears the stored bit and drives the flag low. Both delays are parameters counted in clock cycles.

Top module: `hold_toggle_latch`

## Requirements
- R1: While `rst` is high, `state_q` is 0, `state_qn` is 1, `flag_oe` is 1 and `flag_o` is 0. This takes effect as soon as `rst` rises, without waiting for a clock edge.
- R2: While the synchronized inputs are complementary, `state_q` keeps its value.
- R3: Suppose the inputs become equal before clock edge k. Then the synchronizer passes them on at edge k+2, and `flag_oe` is 0 after edge k+3.
- R4: Suppose equal inputs (both 1 or both 0) are applied before edge k and held. Then `state_q` still has its old value after edge k+HOLD_CYCLES+1. It holds the inverse of that value after edge k+HOLD_CYCLES+2.
- R5: If the equal condition is broken for even one cycle before the hold time expires, the hold count restarts from zero.
- R6: Only one toggle happens per continuous equal hold, however long the hold lasts.
- R7: Suppose the inputs return to complementary before edge k and stay there. Then `flag_oe` remains 0 after edge k+RELEASE_CYCLES+1 and is 1 after edge k+RELEASE_CYCLES+2.
- R8: If the inputs become equal again during the release period, the release count restarts and `flag_oe` stays 0.
- R9: `state_qn` is always the inverse of `state_q`, and `flag_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset, asynchronous assertion |
| pair_a | input | 1 | First input of the nominally complementary pair (asynchronous) |
| pair_b | input | 1 | Second input of the nominally complementary pair (asynchronous) |
| state_q | output | 1 | Stored bit |
| state_qn | output | 1 | Inverse of the stored bit |
| flag_o | output | 1 | Flag data bit; always 0 when driven |
| flag_oe | output | 1 | Flag enable; 0 means high impedance |

## Verification
The properties are written against the synchronized copies of the inputs, not the raw pins. They therefore assume that any glitch on `pair_a` or `pair_b` that is shorter than a clock period simply never reaches the evaluated pair. The bench changes the inputs only on falling clock edges and holds each level for whole cycles, so every level it applies is seen by the synchronizer for a known number of cycles. All expected cycle numbers are counted from the falling edge at which each input change is applied. Interruptions are kept shorter than either delay, so that the restart cases are separated from the ordinary expiry cases.

// File: rtl/ht_pkg.sv
package ht_pkg;

    // Classification of the synchronized input pair.
    typedef enum logic [1:0] {
        PAIR_LO_HI = 2'b01,
        PAIR_HI_LO = 2'b10,
        PAIR_BOTH_LO = 2'b00,
        PAIR_BOTH_HI = 2'b11
    } pair_e;

    // Observable state of the latch.
    typedef struct packed {
        logic held_bit;
        logic flag_hiz;
    } latch_view_t;

    function automatic pair_e classify_pair(input logic a, input logic b);
        return pair_e'({a, b});
    endfunction

    function automatic logic pair_is_fault(input pair_e p);
        return (p == PAIR_BOTH_LO) || (p == PAIR_BOTH_HI);
    endfunction

    // Width able to count from 0 up to n.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ht_sync.sv
module ht_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                chain[w] <= '0;
            end else begin
                chain[w] <= {chain[w][STAGES-2:0], raw_i[w]};
            end
        end
        assign sync_o[w] = chain[w][STAGES-1];
    end
endmodule

// File: rtl/ht_hold_timer.sv
module ht_hold_timer #(
    parameter int HOLD_CYCLES = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_i,
    output logic fire_o
);
    import ht_pkg::*;

    localparam int CW = count_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          spent;

    always_comb begin
        fire_o = fault_i && !spent && (cnt == LAST);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (!fault_i) begin
            cnt   <= '0;
            spent <= 1'b0;
        end else if (fire_o) begin
            cnt   <= '0;
            spent <= 1'b1;
        end else if (!spent) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ht_release_timer.sv
module ht_release_timer #(
    parameter int RELEASE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_i,
    output logic hiz_o
);
    import ht_pkg::*;

    localparam int CW = count_width(RELEASE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          hiz;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            hiz <= 1'b0;
            cnt <= '0;
        end else if (fault_i) begin
            hiz <= 1'b1;
            cnt <= '0;
        end else if (hiz) begin
            if (cnt == LAST) begin
                hiz <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hiz_o = hiz;
endmodule

// File: rtl/hold_toggle_latch.sv
module hold_toggle_latch #(
    parameter int SYNC_STAGES    = 2,
    parameter int HOLD_CYCLES    = 12,
    parameter int RELEASE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic pair_a,
    input  logic pair_b,
    output logic state_q,
    output logic state_qn,
    output logic flag_o,
    output logic flag_oe
);
    import ht_pkg::*;

    logic [1:0]  pair_sync;
    pair_e       pair_cls;
    logic        fault;
    logic        fire;
    logic        hiz;
    latch_view_t view;

    ht_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({pair_a, pair_b}),
        .sync_o (pair_sync)
    );

    always_comb begin
        pair_cls = classify_pair(pair_sync[1], pair_sync[0]);
        fault    = pair_is_fault(pair_cls);
    end

    ht_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .fault_i (fault),
        .fire_o  (fire)
    );

    ht_release_timer #(.RELEASE_CYCLES(RELEASE_CYCLES)) u_release (
        .clk     (clk),
        .rst     (rst),
        .fault_i (fault),
        .hiz_o   (hiz)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            view.held_bit <= 1'b0;
        end else if (fire) begin
            view.held_bit <= ~view.held_bit;
        end
    end

    assign view.flag_hiz = hiz;

    assign state_q  = view.held_bit;
    assign state_qn = ~view.held_bit;
    assign flag_o   = 1'b0;
    assign flag_oe  = ~view.flag_hiz;
endmodule

// File: rtl/hold_toggle_latch_checker.sv
module hold_toggle_latch_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pair_sync,
    input logic       state_q,
    input logic       flag_oe
);
    logic agree;
    assign agree = (pair_sync[1] == pair_sync[0]);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |-> (!state_q && flag_oe));

    a_r2_hold_on_complement: assert property (@(posedge clk) disable iff (rst)
        !agree |=> $stable(state_q));

    a_r3_hiz_on_agree: assert property (@(posedge clk) disable iff (rst)
        agree |=> !flag_oe);

    a_r4_toggle_needs_agree: assert property (@(posedge clk) disable iff (rst)
        !$stable(state_q) |-> $past(agree));

    a_r6_single_toggle: assert property (@(posedge clk) disable iff (rst)
        (!$stable(state_q) && agree) |=> $stable(state_q));

    a_r7_release_after_complement: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_oe) |-> $past(!agree));
endmodule

bind hold_toggle_latch hold_toggle_latch_checker u_checker (
    .clk       (clk),
    .rst       (rst),
    .pair_sync (pair_sync),
    .state_q   (state_q),
    .flag_oe   (flag_oe)
);

// File: tb/hold_toggle_latch_test.sv
module hold_toggle_latch_test;
    localparam int HOLD = 6;
    localparam int REL  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pair_a = 1'b0;
    logic pair_b = 1'b1;
    logic state_q, state_qn, flag_o, flag_oe;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        int    kind;   // 0: state_q, 1: flag_oe
        bit    val;
        string tag;
    } exp_t;

    exp_t sb[$];

    hold_toggle_latch #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .RELEASE_CYCLES(REL)) uut (
        .clk      (clk),
        .rst      (rst),
        .pair_a   (pair_a),
        .pair_b   (pair_b),
        .state_q  (state_q),
        .state_qn (state_qn),
        .flag_o   (flag_o),
        .flag_oe  (flag_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int k, input int kind, input bit val, input string tag);
        exp_t e;
        e.due = cyc + k; e.kind = kind; e.val = val; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        pair_a = a;
        pair_b = b;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares due scoreboard items and the R9 invariants.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                if (sb[i].kind == 0) check(sb[i].tag, state_q, sb[i].val);
                else                 check(sb[i].tag, flag_oe, sb[i].val);
                sb.delete(i);
            end else if (sb[i].due < cyc) begin
                check({sb[i].tag, " missed"}, 1'b0, 1'b1);
                sb.delete(i);
            end
        end
        if (!rst) begin
            check("R9 qn", state_qn, ~state_q);
            check("R9 flag data", flag_o, 1'b0);
        end
    end

    initial begin
        #7_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #1;
        check("R1 q in reset", state_q, 1'b0);
        check("R1 qn in reset", state_qn, 1'b1);
        check("R1 oe in reset", flag_oe, 1'b1);
        check("R1 data in reset", flag_o, 1'b0);
        idle(3);
        rst = 1'b0;

        // R2: complementary both ways keeps state
        drive(1'b1, 1'b0);
        expect_at(8, 0, 1'b0, "R2 hold 10");
        expect_at(8, 1, 1'b1, "R2 driven 10");
        idle(8);
        drive(1'b0, 1'b1);
        expect_at(8, 0, 1'b0, "R2 hold 01");
        idle(10);

        // R3/R4/R6: both high
        drive(1'b1, 1'b1);
        expect_at(2, 1, 1'b1, "R3 still driven");
        expect_at(3, 1, 1'b0, "R3 hiz");
        expect_at(HOLD + 1, 0, 1'b0, "R4 before toggle hi");
        expect_at(HOLD + 2, 0, 1'b1, "R4 toggled hi");
        expect_at(3 * HOLD, 0, 1'b1, "R6 single toggle");
        idle(3 * HOLD + 2);

        // R7: release delay
        drive(1'b1, 1'b0);
        expect_at(REL + 1, 1, 1'b0, "R7 still hiz");
        expect_at(REL + 2, 1, 1'b1, "R7 released");
        expect_at(REL + 2, 0, 1'b1, "R2 after release");
        idle(REL + 6);

        // R4: both low toggles back
        drive(1'b0, 1'b0);
        expect_at(HOLD + 1, 0, 1'b1, "R4 before toggle lo");
        expect_at(HOLD + 2, 0, 1'b0, "R4 toggled lo");
        idle(HOLD + 4);
        drive(1'b0, 1'b1);
        idle(REL + 6);

        // R5: interrupted hold restarts
        drive(1'b1, 1'b1);
        expect_at(HOLD + 2, 0, 1'b0, "R5 no toggle on short hold");
        idle(HOLD - 2);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
        expect_at(HOLD + 1, 0, 1'b0, "R5 before restarted expiry");
        expect_at(HOLD + 2, 0, 1'b1, "R5 toggled after full hold");
        idle(HOLD + 4);
        drive(1'b0, 1'b1);
        idle(REL + 6);

        // R8: release restarts on re-agreement
        drive(1'b0, 1'b0);
        idle(2);
        drive(1'b0, 1'b1);
        idle(REL - 3);
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        expect_at(REL + 1, 1, 1'b0, "R8 still hiz after restart");
        expect_at(REL + 2, 1, 1'b1, "R8 released after restart");
        expect_at(REL + 6, 0, 1'b1, "R8 short glitch no toggle");
        idle(REL + 8);

        // R1: asynchronous reset mid-run
        @(negedge clk);
        #3 rst = 1'b1;
        #1;
        check("R1 async q", state_q, 1'b0);
        check("R1 async qn", state_qn, 1'b1);
        check("R1 async oe", flag_oe, 1'b1);
        idle(3);
        rst = 1'b0;
        idle(4);

        if (sb.size() != 0) check("scoreboard drained", 1'b0, 1'b1);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule